// File: doc/BRIEF.md
# Successive-Approximation Converter Phase Sequencer

This block paces a successive-approximation converter through its phases. The converter's analog parts and bit search are not modelled here; they appear only as timing windows. Everything runs on one master clock. After reset the block first runs a calibration window. It then waits in fine tracking. An active-low sample request, which may come from outside the clock domain, is synchronized. Its falling edge opens a conversion window of fixed length. When the window closes, a short coarse-charge window follows, and then fine tracking resumes.

When both mode-select bits are zero, the block paces itself instead. It starts one conversion every fixed number of clocks and ignores the sample request. An active-low sleep input parks the block with all phase strobes low. Leaving sleep returns straight to tracking without a new calibration. If the sample request is still low at the end of a conversion, a new conversion starts at once. This repeats the short-acquisition behaviour of the converter it sequences.

Top module: `sar_phase_sequencer`

## Requirements
- R1: After reset release, `cal_busy_o` stays high for CAL_CYCLES+1 clock samples: two cycles of reset synchronization, then CAL_CYCLES-1 more. It then falls to fine tracking and never rises again until the next reset. No conversion starts while it is high.
- R2: A falling edge on `sample_ni` is seen through a two-stage synchronizer. `conv_busy_o` rises after the third rising clock edge that follows the input change.
- R3: `conv_busy_o` stays high for exactly CONV_CYCLES (default 66) cycles. `done_o` pulses for one cycle, on the last of them.
- R4: The cycle after every conversion, `coarse_o` is high for exactly COARSE_CYCLES (default 6) cycles. `fine_o` follows, unless a new start or a sleep request cuts the window short. At most one of the four phase strobes is high at a time.
- R5: With `mode_i` equal to 2'b00, conversions start every RUN_PERIOD (default 80) clocks. `run_tick_o` pulses in the cycle before each start, and `sample_ni` has no effect.
- R6: Sample-request edges during calibration or during a conversion are dropped. If `sample_ni` is back high when the conversion ends, no further conversion follows.
- R7: While `sleep_ni` is low and no conversion is running, all phase strobes are low and no conversion starts. Sleep wins over a start that falls in the same cycle, and that start is lost. Releasing sleep gives `fine_o` without calibration.
- R8: If `sample_ni` is still low (synchronized) on the last conversion cycle, the next conversion starts after a single coarse-charge cycle.
- R9: A sleep request raised during a conversion lets it run its full length. Sleep begins after one coarse-charge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sleep_ni | input | 1 | Active-low sleep request |
| sample_ni | input | 1 | Asynchronous active-low sample request; falling edge starts a conversion |
| mode_i | input | 2 | Mode select; 2'b00 selects self-paced conversion |
| cal_busy_o | output | 1 | Calibration window active |
| conv_busy_o | output | 1 | Conversion window active |
| coarse_o | output | 1 | Coarse-charge window active |
| fine_o | output | 1 | Fine tracking (acquisition) active |
| done_o | output | 1 | One-cycle pulse on the last conversion cycle |
| run_tick_o | output | 1 | Self-paced start strobe, one cycle before the conversion window |

## Verification
The two events that meet in one cycle are a conversion start and a sleep request. The bench drives the sample request low and then waits until the synchronized edge is about to start a conversion. In that very cycle it lowers the sleep input. The reference model expects sleep to win, with every strobe low and the request dropped for good. A second collision is a retrigger start on the first coarse-charge cycle. The bench judges it by a coarse window that lasts exactly one sample.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    PH_CAL    = 3'd0,
    PH_FINE   = 3'd1,
    PH_CONV   = 3'd2,
    PH_COARSE = 3'd3,
    PH_SLEEP  = 3'd4
  } phase_e;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/sar_seq_rst_sync.sv
module sar_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/sar_seq_req_sync.sv
module sar_seq_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic level_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], req_ni};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level_o = sync_q[STAGES-1];
  assign fall_o  = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/sar_seq_pacer.sv
module sar_seq_pacer #(
  parameter int PERIOD = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  output logic due_o
);
  localparam int W = $clog2(PERIOD + 1);

  logic [W-1:0] pace_q;
  logic [W-1:0] pace_d;
  logic         sat;

  assign sat = (pace_q == W'(PERIOD));

  always_comb begin
    pace_d = pace_q;
    if (restart_i) begin
      pace_d = W'(1);
    end else if (!sat) begin
      pace_d = pace_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pace_q <= W'(PERIOD);
    end else begin
      pace_q <= pace_d;
    end
  end

  assign due_o = sat;
endmodule

// File: rtl/sar_phase_sequencer.sv
module sar_phase_sequencer
  import sar_seq_pkg::*;
#(
  parameter int CAL_CYCLES    = 1024,
  parameter int CONV_CYCLES   = 66,
  parameter int COARSE_CYCLES = 6,
  parameter int RUN_PERIOD    = 80,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sleep_ni,
  input  logic       sample_ni,
  input  logic [1:0] mode_i,
  output logic       cal_busy_o,
  output logic       conv_busy_o,
  output logic       coarse_o,
  output logic       fine_o,
  output logic       done_o,
  output logic       run_tick_o
);
  localparam int CNT_MAX = (max3(CAL_CYCLES, CONV_CYCLES, COARSE_CYCLES) < 2) ? 2 :
                           max3(CAL_CYCLES, CONV_CYCLES, COARSE_CYCLES);
  localparam int CNT_W   = $clog2(CNT_MAX);

  logic rst_sync_n;
  logic req_level, req_fall;
  logic pace_due;

  phase_e            state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              armed_q, armed_d;

  logic cal_last, conv_last, coarse_last, in_track;
  logic self_paced, hold_req, pace_req, start;
  logic cnt_en;

  sar_seq_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  sar_seq_req_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .req_ni  (sample_ni),
    .level_o (req_level),
    .fall_o  (req_fall)
  );

  sar_seq_pacer #(.PERIOD(RUN_PERIOD)) u_pacer (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .restart_i (start),
    .due_o     (pace_due)
  );

  // window end flags
  assign cal_last    = (state_q == PH_CAL)    && (cnt_q == CNT_W'(CAL_CYCLES - 1));
  assign conv_last   = (state_q == PH_CONV)   && (cnt_q == CNT_W'(CONV_CYCLES - 1));
  assign coarse_last = (state_q == PH_COARSE) && (cnt_q == CNT_W'(COARSE_CYCLES - 1));
  assign in_track    = (state_q == PH_COARSE) || (state_q == PH_FINE);

  // start qualification
  assign self_paced  = (mode_i == 2'b00);
  assign hold_req    = ~self_paced & (req_fall | (armed_q & ~req_level));
  assign pace_req    = self_paced & pace_due;
  assign start       = in_track & sleep_ni & (hold_req | pace_req);

  // next phase
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PH_CAL: begin
        if (cal_last) state_d = PH_FINE;
      end
      PH_CONV: begin
        if (conv_last) state_d = PH_COARSE;
      end
      PH_COARSE: begin
        if (!sleep_ni)        state_d = PH_SLEEP;
        else if (start)       state_d = PH_CONV;
        else if (coarse_last) state_d = PH_FINE;
      end
      PH_FINE: begin
        if (!sleep_ni)   state_d = PH_SLEEP;
        else if (start)  state_d = PH_CONV;
      end
      PH_SLEEP: begin
        if (sleep_ni) state_d = PH_FINE;
      end
      default: state_d = PH_CAL;
    endcase
  end

  // shared window counter
  assign cnt_en = (state_q == PH_CAL) || (state_q == PH_CONV) || (state_q == PH_COARSE);

  always_comb begin
    cnt_d = cnt_q;
    if (state_d != state_q) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  // retrigger arming: request still low at end of conversion
  always_comb begin
    armed_d = armed_q;
    if (req_level)      armed_d = 1'b0;
    else if (conv_last) armed_d = 1'b1;
    else if (start)     armed_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= PH_CAL;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      armed_q <= armed_d;
    end
  end

  assign cal_busy_o  = (state_q == PH_CAL);
  assign conv_busy_o = (state_q == PH_CONV);
  assign coarse_o    = (state_q == PH_COARSE);
  assign fine_o      = (state_q == PH_FINE);
  assign done_o      = conv_last;
  assign run_tick_o  = start & self_paced;
endmodule

// File: rtl/sar_seq_checker.sv
module sar_seq_checker #(
  parameter int CONV_CYCLES   = 66,
  parameter int COARSE_CYCLES = 6
) (
  input logic clk_i,
  input logic rst_ni,
  input logic sleep_ni,
  input logic cal_busy_i,
  input logic conv_busy_i,
  input logic coarse_i,
  input logic fine_i,
  input logic done_i,
  input logic tick_i
);
  int   conv_run_q;
  int   coarse_run_q;
  logic cal_prev_q;
  logic cal_over_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      conv_run_q   <= 0;
      coarse_run_q <= 0;
      cal_prev_q   <= 1'b1;
      cal_over_q   <= 1'b0;
    end else begin
      conv_run_q   <= conv_busy_i ? conv_run_q + 1 : 0;
      coarse_run_q <= coarse_i ? coarse_run_q + 1 : 0;
      cal_prev_q   <= cal_busy_i;
      if (cal_prev_q && !cal_busy_i) cal_over_q <= 1'b1;
    end
  end

  assert_phase_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cal_busy_i, conv_busy_i, coarse_i, fine_i}));

  assert_done_on_last_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (conv_busy_i && conv_run_q == CONV_CYCLES - 1));

  assert_conv_bounded_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_busy_i |-> (conv_run_q < CONV_CYCLES));

  assert_coarse_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> (coarse_i && !conv_busy_i));

  assert_coarse_bounded_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coarse_i |-> (coarse_run_q < COARSE_CYCLES));

  assert_no_recal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_over_q |-> !cal_busy_i);

  assert_tick_starts_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> conv_busy_i);

  assert_sleep_blocks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sleep_ni && !conv_busy_i) |=> !conv_busy_i);
endmodule

bind sar_phase_sequencer sar_seq_checker #(
  .CONV_CYCLES   (CONV_CYCLES),
  .COARSE_CYCLES (COARSE_CYCLES)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_sync_n),
  .sleep_ni    (sleep_ni),
  .cal_busy_i  (cal_busy_o),
  .conv_busy_i (conv_busy_o),
  .coarse_i    (coarse_o),
  .fine_i      (fine_o),
  .done_i      (done_o),
  .tick_i      (run_tick_o)
);

// File: tb/sar_phase_sequencer_tb_top.sv
module sar_phase_sequencer_tb_top;
  localparam int CAL    = 1024;
  localparam int CONV   = 66;
  localparam int COARSE = 6;
  localparam int PERIOD = 80;

  logic       clk = 1'b0;
  logic       rst_n, sleep_n, hold_n;
  logic [1:0] mode;
  logic       cal_busy, conv_busy, coarse, fine, done, tick;

  always #10 clk = ~clk;

  sar_phase_sequencer #(
    .CAL_CYCLES(CAL), .CONV_CYCLES(CONV), .COARSE_CYCLES(COARSE),
    .RUN_PERIOD(PERIOD), .SYNC_STAGES(2)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sleep_ni(sleep_n), .sample_ni(hold_n),
    .mode_i(mode), .cal_busy_o(cal_busy), .conv_busy_o(conv_busy),
    .coarse_o(coarse), .fine_o(fine), .done_o(done), .run_tick_o(tick)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  bit cmp_on = 1'b0;
  int cyc = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      #2;
    end
  endtask

  // reference model: 0 cal, 1 fine, 2 conv, 3 coarse, 4 sleep
  int m_st = 0, m_cnt = 0, m_age = 0, m_pace = PERIOD;
  bit m_h1 = 1, m_h2 = 1, m_hp = 1, m_armed = 0;

  always @(posedge clk) begin : model
    bit lvl, fall, fr, trk, go;
    int nst;
    if (!rst_n) begin
      m_age = 0; m_st = 0; m_cnt = 0; m_pace = PERIOD;
      m_h1 = 1; m_h2 = 1; m_hp = 1; m_armed = 0;
    end else if (m_age < 2) begin
      m_age++;
    end else begin
      lvl  = m_h2;
      fall = m_hp && !m_h2;
      fr   = (mode == 2'b00);
      trk  = (m_st == 1) || (m_st == 3);
      go   = trk && sleep_n && (fr ? (m_pace == PERIOD) : (fall || (m_armed && !lvl)));
      nst  = m_st;
      case (m_st)
        0: if (m_cnt == CAL - 1) nst = 1;
        2: if (m_cnt == CONV - 1) nst = 3;
        3: if (!sleep_n) nst = 4; else if (go) nst = 2; else if (m_cnt == COARSE - 1) nst = 1;
        1: if (!sleep_n) nst = 4; else if (go) nst = 2;
        default: if (sleep_n) nst = 1;
      endcase
      if (lvl) m_armed = 0;
      else if (m_st == 2 && m_cnt == CONV - 1) m_armed = 1;
      else if (go) m_armed = 0;
      if (go) m_pace = 1; else if (m_pace < PERIOD) m_pace++;
      m_cnt = (nst != m_st) ? 0 : m_cnt + 1;
      m_st  = nst;
      m_hp = m_h2; m_h2 = m_h1; m_h1 = hold_n;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R1", "cal_busy", int'(cal_busy), int'(m_st == 0));
      chk("R3", "conv_busy", int'(conv_busy), int'(m_st == 2));
      chk("R3", "done", int'(done), int'(m_st == 2 && m_cnt == CONV - 1));
      chk("R4", "coarse", int'(coarse), int'(m_st == 3));
      chk("R4", "fine", int'(fine), int'(m_st == 1));
      chk("R5", "run_tick", int'(tick),
          int'((m_st == 1 || m_st == 3) && sleep_n && mode == 2'b00 && m_pace == PERIOD));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 60000) begin
      fails++;
      $display("FAIL watchdog: cycles actual %0d expected below %0d", cyc, 60000);
      finish_run();
    end
  end

  initial begin
    int n, c, d, k;
    rst_n = 0; sleep_n = 1; hold_n = 1; mode = 2'b01;
    step(3);
    cmp_on = 1;
    chk("R1", "cal during reset", int'(cal_busy), 1);
    rst_n = 1;

    // R1 calibration length, R6 request during calibration ignored
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      step(1);
      if (!cal_busy) break;
      n++;
      if (n == 100) hold_n = 0;
      if (n == 105) hold_n = 1;
    end
    chk("R1", "calibration samples", n, CAL + 1);
    chk("R1", "fine after calibration", int'(fine), 1);
    n = 0;
    for (int i = 0; i < 10; i++) begin step(1); n += int'(conv_busy); end
    chk("R6", "conversions after cal-time request", n, 0);

    // R2 latency, R3 length, R4 coarse
    hold_n = 0; n = 0;
    for (int i = 0; i < 20; i++) begin step(1); n++; if (conv_busy) break; end
    chk("R2", "edge to conversion samples", n, 3);
    c = 1; d = int'(done);
    for (int i = 0; i < 200; i++) begin
      step(1);
      if (!conv_busy) break;
      c++; d += int'(done);
      if (c == 5) hold_n = 1;
    end
    chk("R3", "conversion samples", c, CONV);
    chk("R3", "done pulses", d, 1);
    k = 0;
    for (int i = 0; i < 50; i++) begin if (!coarse) break; k++; step(1); end
    chk("R4", "coarse samples", k, COARSE);
    chk("R4", "fine after coarse", int'(fine), 1);

    // R6 edge inside a conversion dropped
    hold_n = 0;
    for (int i = 0; i < 20; i++) begin step(1); if (conv_busy) break; end
    c = 1;
    for (int i = 0; i < 200; i++) begin
      step(1);
      if (!conv_busy) break;
      c++;
      if (c == 10) hold_n = 1;
      if (c == 20) hold_n = 0;
      if (c == 30) hold_n = 1;
    end
    n = 0;
    for (int i = 0; i < 40; i++) begin step(1); n += int'(conv_busy); end
    chk("R6", "conversions after in-conversion edge", n, 0);

    // R8 level retrigger
    hold_n = 0;
    for (int i = 0; i < 20; i++) begin step(1); if (conv_busy) break; end
    for (int i = 0; i < 200; i++) begin step(1); if (!conv_busy) break; end
    k = 0;
    for (int i = 0; i < 50; i++) begin if (!coarse) break; k++; step(1); end
    chk("R8", "coarse samples before retrigger", k, 1);
    chk("R8", "retriggered conversion", int'(conv_busy), 1);
    hold_n = 1;
    for (int i = 0; i < 200; i++) begin step(1); if (fine) break; end

    // R7 sleep
    sleep_n = 0; step(2);
    chk("R7", "strobes in sleep", int'({cal_busy, conv_busy, coarse, fine}), 0);
    hold_n = 0; step(5); hold_n = 1;
    n = 0;
    for (int i = 0; i < 5; i++) begin step(1); n += int'(conv_busy); end
    chk("R7", "conversions during sleep", n, 0);
    sleep_n = 1; step(2);
    chk("R7", "fine after wake", int'(fine), 1);
    chk("R7", "no recalibration", int'(cal_busy), 0);

    // R7 sleep and start in the same cycle
    hold_n = 0; step(2);
    sleep_n = 0;
    n = 0;
    for (int i = 0; i < 10; i++) begin step(1); n += int'(conv_busy) + int'(coarse) + int'(fine); end
    chk("R7", "strobes when sleep meets start", n, 0);
    sleep_n = 1;
    n = 0;
    for (int i = 0; i < 10; i++) begin step(1); n += int'(conv_busy); end
    chk("R7", "lost start stays lost", n, 0);
    hold_n = 1; step(3);

    // R9 sleep raised during a conversion
    hold_n = 0;
    for (int i = 0; i < 20; i++) begin step(1); if (conv_busy) break; end
    c = 1;
    for (int i = 0; i < 200; i++) begin
      step(1);
      if (!conv_busy) break;
      c++;
      if (c == 10) begin sleep_n = 0; hold_n = 1; end
    end
    chk("R9", "conversion samples under sleep", c, CONV);
    k = 0;
    for (int i = 0; i < 50; i++) begin if (!coarse) break; k++; step(1); end
    chk("R9", "coarse samples before sleep", k, 1);
    chk("R9", "strobes in sleep", int'({cal_busy, conv_busy, coarse, fine}), 0);
    sleep_n = 1; step(2);
    chk("R9", "fine after wake", int'(fine), 1);

    // R5 self-paced mode, request toggling ignored
    mode = 2'b00;
    n = 0;
    for (int i = 0; i < 200; i++) begin
      if (tick) break;
      hold_n = ((i % 14) < 7);
      step(1);
    end
    chk("R5", "first tick seen", int'(tick), 1);
    for (int r = 0; r < 3; r++) begin
      step(1);
      chk("R5", "conversion after tick", int'(conv_busy), 1);
      n = 1;
      for (int i = 0; i < 300; i++) begin
        if (tick) break;
        hold_n = ((i % 14) < 7);
        step(1);
        n++;
      end
      n--;
      chk("R5", "tick interval", n + 1, PERIOD);
    end
    mode = 2'b01; hold_n = 1;
    step(200);
    finish_run();
  end
endmodule